// File: doc/BRIEF.md
# CCD Line Pixel Region Sequencer

This block walks through the output pixels of one line of a three-colour linear CCD. It runs in step with the timing generator's pixel clock. A line start arms it. Each accepted pixel strobe then advances a position count, and the block labels that pixel with one of four region codes: leading dummy, optical black, effective, or trailing dummy. For effective pixels it raises a strobe that marks a valid ADC sample, and it gives a zero-based effective-pixel index.

Each line also yields a black-reference level. The block sums the digitised samples of a fixed run of early dummy pixels and divides the sum by the number of samples. The result is held until the next window finishes. After the last pixel of the line it pulses a line-end flag and ignores any further strobes until the next line start. Every output is registered, so each one appears on the cycle after the strobe that caused it.

Top module: `ccd_line_sequencer`

## Requirements
- R1: While reset is held and after it is released, pix_valid, sample_valid, line_end and black_upd are 0, black_level is 0, region is 0 and eff_index is 0. Pixel strobes seen before the first line_start are ignored.
- R2: A strobe accepted in cycle t gives pix_valid=1 in cycle t+1, with region set for that pixel's 1-based number n. Pixels 1..13 and 63 give code 0 (leading dummy), 14..62 give code 1 (optical black), 64..2763 give code 2 (effective) and 2764..2770 give code 3 (trailing dummy).
- R3: eff_index is n-64 on effective pixels and 0 on all other accepted pixels. sample_valid is 1 exactly on the cycles where pix_valid=1 and region=2.
- R4: line_end pulses for one cycle, together with pix_valid, for pixel 2770.
- R5: Once pixel 2770 has been accepted, further strobes produce no pix_valid until the next line_start.
- R6: A line_start in any cycle restarts numbering at pixel 1. A pix_stb in the same cycle as line_start is ignored.
- R7: black_level becomes the truncated quotient of the sum of pix_data over pixels 2..12 divided by 11. It is presented on the cycle after pixel 12 is accepted, with a one-cycle black_upd pulse.
- R8: black_level changes only with black_upd. A line restarted before pixel 12 leaves it unchanged, and its partial sum is discarded.
- R9: On cycles with no accepted strobe, pix_valid=0 and region and eff_index keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Arms and restarts the line count |
| pix_stb | input | 1 | One pulse per output pixel |
| pix_data | input | 12 | Digitised sample of the strobed pixel |
| pix_valid | output | 1 | An accepted pixel was decoded |
| region | output | 2 | Region code of the last accepted pixel |
| sample_valid | output | 1 | Effective pixel sample strobe |
| eff_index | output | 12 | Zero-based effective pixel index |
| black_level | output | 12 | Averaged black reference |
| black_upd | output | 1 | black_level was refreshed this cycle |
| line_end | output | 1 | Last pixel of the line was decoded |

## Verification
On every cycle the checker tests a set of local relations. Sample strobes occur only on decoded effective pixels. Line end coincides with a decoded trailing pixel and is followed by a quiet cycle. The black level moves only together with its update flag. The sample, update and line-end pulses never overlap. The actual pixel counts cannot be seen locally: the region boundaries, the index values, the averaged value, the lockout after the last pixel and the effect of restarts. Only the bench's reference model can show these, driven through full lines, gapped strobes, aborted lines and strobes that coincide with a line start.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
  typedef enum logic [1:0] {
    RG_LEAD  = 2'd0,
    RG_OBLK  = 2'd1,
    RG_EFF   = 2'd2,
    RG_TRAIL = 2'd3
  } region_e;
endpackage

// File: rtl/ccdseq_pos_counter.sv
module ccdseq_pos_counter #(
  parameter int TOTAL = 2770,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          pix_stb,
  output logic          accept,
  output logic [CW-1:0] pix_num
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign accept  = pix_stb & act_q & ~line_start;
  assign pix_num = cnt_q + CW'(1);
  assign cnt_en  = line_start | accept;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (line_start) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (accept) begin
      cnt_d = pix_num;
      if (pix_num == CW'(TOTAL)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/ccdseq_region_decode.sv
module ccdseq_region_decode
  import ccdseq_pkg::*;
#(
  parameter int LEAD      = 63,
  parameter int OB_FIRST  = 14,
  parameter int OB_LAST   = 62,
  parameter int EFF_N     = 2700,
  parameter int TOTAL     = 2770,
  parameter int BLK_FIRST = 2,
  parameter int BLK_LAST  = 12,
  localparam int CW = $clog2(TOTAL + 1),
  localparam int IW = $clog2(EFF_N)
) (
  input  logic [CW-1:0] pix_num,
  output region_e       region,
  output logic [IW-1:0] eff_idx,
  output logic          last,
  output logic          blk_in,
  output logic          blk_end
);
  localparam int EFF_LAST = LEAD + EFF_N;
  logic [CW-1:0] off;

  assign off = pix_num - CW'(LEAD + 1);

  always_comb begin
    if (pix_num <= CW'(LEAD)) begin
      if (pix_num >= CW'(OB_FIRST) && pix_num <= CW'(OB_LAST)) region = RG_OBLK;
      else region = RG_LEAD;
    end else if (pix_num <= CW'(EFF_LAST)) begin
      region = RG_EFF;
    end else begin
      region = RG_TRAIL;
    end
    eff_idx = (region == RG_EFF) ? off[IW-1:0] : '0;
  end

  assign last    = (pix_num == CW'(TOTAL));
  assign blk_in  = (pix_num >= CW'(BLK_FIRST)) && (pix_num <= CW'(BLK_LAST));
  assign blk_end = (pix_num == CW'(BLK_LAST));
endmodule

// File: rtl/ccdseq_black_avg.sv
module ccdseq_black_avg #(
  parameter int DATA_W = 12,
  parameter int BLK_N  = 11,
  localparam int ACC_W = DATA_W + $clog2(BLK_N) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              fin,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] level,
  output logic              upd
);
  logic [ACC_W-1:0]  acc_q, acc_d, sum;
  logic [ACC_W-1:0]  quo;
  logic [DATA_W-1:0] lvl_d;
  logic              acc_en, lvl_en;

  assign sum = acc_q + ACC_W'(data);

  generate
    if ((BLK_N & (BLK_N - 1)) == 0) begin : g_shift
      assign quo = sum >> $clog2(BLK_N);
    end else begin : g_div
      assign quo = sum / ACC_W'(BLK_N);
    end
  endgenerate

  always_comb begin
    acc_d = acc_q;
    lvl_d = level;
    if (clr) begin
      acc_d = '0;
    end else if (fin) begin
      acc_d = '0;
      lvl_d = DATA_W'(quo);
    end else if (take) begin
      acc_d = sum;
    end
  end

  assign acc_en = clr | take | fin;
  assign lvl_en = fin & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else if (lvl_en) level <= lvl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd <= 1'b0;
    else upd <= lvl_en;
  end
endmodule

// File: rtl/ccd_line_sequencer.sv
module ccd_line_sequencer
  import ccdseq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD      = 63,
  parameter int OB_FIRST  = 14,
  parameter int OB_LAST   = 62,
  parameter int EFF_N     = 2700,
  parameter int TRAIL     = 7,
  parameter int BLK_FIRST = 2,
  parameter int BLK_LAST  = 12,
  localparam int IW = $clog2(EFF_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              pix_stb,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic [1:0]        region,
  output logic              sample_valid,
  output logic [IW-1:0]     eff_index,
  output logic [DATA_W-1:0] black_level,
  output logic              black_upd,
  output logic              line_end
);
  localparam int TOTAL = LEAD + EFF_N + TRAIL;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int BLK_N = BLK_LAST - BLK_FIRST + 1;

  logic          accept;
  logic [CW-1:0] pix_num;
  region_e       rg_c;
  logic [IW-1:0] idx_c;
  logic          last_c, blk_in_c, blk_end_c;

  region_e       rg_q;
  logic [IW-1:0] idx_q;
  logic          pv_q, sv_q, le_q;

  ccdseq_pos_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .pix_stb    (pix_stb),
    .accept     (accept),
    .pix_num    (pix_num)
  );

  ccdseq_region_decode #(
    .LEAD(LEAD), .OB_FIRST(OB_FIRST), .OB_LAST(OB_LAST), .EFF_N(EFF_N),
    .TOTAL(TOTAL), .BLK_FIRST(BLK_FIRST), .BLK_LAST(BLK_LAST)
  ) u_dec (
    .pix_num (pix_num),
    .region  (rg_c),
    .eff_idx (idx_c),
    .last    (last_c),
    .blk_in  (blk_in_c),
    .blk_end (blk_end_c)
  );

  ccdseq_black_avg #(.DATA_W(DATA_W), .BLK_N(BLK_N)) u_blk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (line_start),
    .take  (accept & blk_in_c),
    .fin   (accept & blk_end_c),
    .data  (pix_data),
    .level (black_level),
    .upd   (black_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rg_q  <= RG_LEAD;
      idx_q <= '0;
    end else if (accept) begin
      rg_q  <= rg_c;
      idx_q <= idx_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      sv_q <= 1'b0;
      le_q <= 1'b0;
    end else begin
      pv_q <= accept;
      sv_q <= accept & (rg_c == RG_EFF);
      le_q <= accept & last_c;
    end
  end

  assign pix_valid    = pv_q;
  assign region       = rg_q;
  assign sample_valid = sv_q;
  assign eff_index    = idx_q;
  assign line_end     = le_q;
endmodule

module ccdseq_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [1:0]        region,
  input logic              sample_valid,
  input logic [DATA_W-1:0] black_level,
  input logic              black_upd,
  input logic              line_end
);
  // R3
  sample_only_on_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (pix_valid && region == 2'd2));
  // R4
  line_end_on_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> (pix_valid && region == 2'd3));
  // R5
  quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !pix_valid);
  // R8
  black_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !black_upd |-> $stable(black_level));
  // R7
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_valid, black_upd, line_end}));
  // R7
  black_upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    black_upd |=> !black_upd);
endmodule

bind ccd_line_sequencer ccdseq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_valid    (pix_valid),
  .region       (region),
  .sample_valid (sample_valid),
  .black_level  (black_level),
  .black_upd    (black_upd),
  .line_end     (line_end)
);

// File: tb/tb_ccd_line_sequencer.sv
`timescale 1ns/1ps
module tb_ccd_line_sequencer;
  logic        clk, rst_n, line_start, pix_stb;
  logic [11:0] pix_data;
  logic        pix_valid, sample_valid, black_upd, line_end;
  logic [1:0]  region;
  logic [11:0] eff_index, black_level;

  int checks = 0, fails = 0;
  bit cmp_en = 0;

  ccd_line_sequencer dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_stb(pix_stb),
    .pix_data(pix_data), .pix_valid(pix_valid), .region(region),
    .sample_valid(sample_valid), .eff_index(eff_index),
    .black_level(black_level), .black_upd(black_upd), .line_end(line_end)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_act, m_n, m_sum;
  int e_pv, e_rg, e_ix, e_sv, e_le, e_bl, e_bu;
  int pv_seen;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_n = 0; m_sum = 0;
      e_pv = 0; e_rg = 0; e_ix = 0; e_sv = 0; e_le = 0; e_bl = 0; e_bu = 0;
    end else begin
      e_pv = 0; e_sv = 0; e_le = 0; e_bu = 0;
      if (line_start) begin
        m_act = 1; m_n = 0; m_sum = 0;
      end else if (pix_stb && m_act == 1) begin
        m_n++;
        e_pv = 1;
        if (m_n >= 2 && m_n <= 12) m_sum += int'(pix_data);
        if (m_n == 12) begin e_bl = m_sum / 11; e_bu = 1; end
        if (m_n <= 63) e_rg = (m_n >= 14 && m_n <= 62) ? 1 : 0;
        else if (m_n <= 2763) e_rg = 2;
        else e_rg = 3;
        e_ix = (e_rg == 2) ? m_n - 64 : 0;
        e_sv = (e_rg == 2) ? 1 : 0;
        if (m_n == 2770) begin e_le = 1; m_act = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(int'(pix_valid) == e_pv, "R2/R5/R6/R9 pix_valid", int'(pix_valid), e_pv);
      chk(int'(region) == e_rg, "R2/R9 region", int'(region), e_rg);
      chk(int'(eff_index) == e_ix, "R3 eff_index", int'(eff_index), e_ix);
      chk(int'(sample_valid) == e_sv, "R3 sample_valid", int'(sample_valid), e_sv);
      chk(int'(line_end) == e_le, "R4 line_end", int'(line_end), e_le);
      chk(int'(black_level) == e_bl, "R7/R8 black_level", int'(black_level), e_bl);
      chk(int'(black_upd) == e_bu, "R7 black_upd", int'(black_upd), e_bu);
      if (pix_valid) pv_seen++;
    end
  end

  task automatic start_line(input bit with_stb);
    @(negedge clk);
    line_start = 1; pix_stb = with_stb; pix_data = 12'hFFF;
    @(negedge clk);
    line_start = 0; pix_stb = 0;
    pv_seen = 0;
  endtask

  // gap_mode 0: back-to-back; 1: random gaps 0..3; data_mode 0: n*37 pattern; 1: random
  task automatic strobes(input int n, input int gap_mode, input int data_mode);
    for (int k = 1; k <= n; k++) begin
      if (gap_mode == 1) repeat ($urandom_range(0, 3)) @(negedge clk);
      pix_stb = 1;
      pix_data = (data_mode == 0) ? 12'((k * 37) % 4096) : 12'($urandom_range(0, 4095));
      @(negedge clk);
      pix_stb = 0;
    end
  endtask

  initial begin
    rst_n = 0; line_start = 0; pix_stb = 0; pix_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pix_valid == 0 && sample_valid == 0 && line_end == 0 && black_upd == 0,
        "R1 reset pulses", int'(pix_valid), 0);
    chk(region == 0 && eff_index == 0 && black_level == 0, "R1 reset values",
        int'(black_level), 0);
    rst_n = 1;
    cmp_en = 1;
    // R1: strobes before first line start are ignored
    pv_seen = 0;
    strobes(5, 0, 0);
    repeat (2) @(negedge clk);
    chk(pv_seen == 0, "R1 strobes before line_start", pv_seen, 0);

    // Full line, back-to-back, pattern data
    start_line(0);
    strobes(2770, 0, 0);
    repeat (2) @(negedge clk);
    chk(black_level == 12'd259, "R7 black average", int'(black_level), 259);
    chk(pv_seen == 2770, "R4 pixels per line", pv_seen, 2770);
    // R5: extra strobes after the last pixel are ignored
    strobes(20, 1, 1);
    repeat (2) @(negedge clk);
    chk(pv_seen == 2770, "R5 strobes after line end", pv_seen, 2770);

    // R6: restart mid-line with a coincident strobe, R8: abort before window end
    start_line(1);
    strobes(6, 1, 1);
    start_line(0);
    strobes(30, 1, 1);
    start_line(1);
    strobes(2770, 1, 1);
    repeat (3) @(negedge clk);
    chk(pv_seen == 2770, "R6 restarted line count", pv_seen, 2770);

    // Another full line with gaps and random data
    start_line(0);
    strobes(2780, 1, 1);
    repeat (3) @(negedge clk);
    chk(pv_seen == 2770, "R5 gapped line count", pv_seen, 2770);

    cmp_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule